// File: doc/BRIEF.md
# Carry-skip adder

A purely combinational adder for two unsigned operands plus an incoming carry. The operand width is cut into equal groups of bits (by default a 16-bit adder in four 4-bit groups). Inside each group the carry ripples bit by bit through full-adder cells. Beside each group sits a bypass: when every bit of the group would pass a carry along, a multiplexer forwards the group's incoming carry directly to the next group. Otherwise the carry formed by the group's own ripple chain goes on.

Each bit forms a generate term, the AND of its operand bits, and a propagate term, the XOR of its operand bits. Because propagate is an XOR, each sum bit is simply the propagate term XOR the carry into that bit. The group skip selects are brought out as a vector so that a test environment can see which groups took the bypass for a given operand pair. The adder holds no state and has no clock.

Top module: `skip_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `op_a + op_b + carry_in` for every input combination.
- R2: `carry_out` equals bit 16 of `op_a + op_b + carry_in`.
- R3: `grp_skip[k]` is 1 exactly when `op_a ^ op_b` is all ones in bits 4k to 4k+3. Bit 0 of the vector belongs to bits 3:0 and bit 3 belongs to bits 15:12.
- R4: When all four skip selects are 1, `carry_out` equals `carry_in` and every `sum` bit equals the inverse of `carry_in`.
- R5: When the top group (bits 15:12) does not skip, `carry_out` is the carry out of `op_a[15:12] + op_b[15:12]`, whatever the value of `carry_in` and the lower bits.
- R6: With all inputs at 0, `sum`, `carry_out` and `grp_skip` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Low bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |
| grp_skip | output | 4 | Per-group bypass select, bit k for bits 4k+3:4k |

## Verification
The main corner is a carry that enters a fully propagating group and has to reach both the next group, through the bypass, and the group's own sum bits, through its ripple chain. A design that only fed the mux would leave wrong sum bits inside skipped groups, and a chain of all-propagate groups (0xFFFF plus 0 plus 1) shows this at once as a non-zero sum. The bench walks all sixteen patterns of skipping and non-skipping groups under both carry-in values, so a mux with inverted select or a select built from the wrong group's bits would send a stale carry forward. It also sweeps one group's nibbles and the carry-in exhaustively, with pseudo-random data elsewhere, and toggles the carry-in under a generating or killing top group to catch a carry-out that wrongly follows the bypass.

// File: rtl/skip_adder.sv
module skip_adder #(
  parameter int W = 16,
  parameter int G = 4
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           carry_in,
  output logic [W-1:0]   sum,
  output logic           carry_out,
  output logic [W/G-1:0] grp_skip
);
  localparam int N = W / G;

  logic [W-1:0] prop;
  logic [W-1:0] gen;

  assign prop = op_a ^ op_b;
  assign gen  = op_a & op_b;

  always_comb begin
    logic grp_c;
    logic bit_c;
    logic all_p;
    grp_c    = carry_in;
    sum      = '0;
    grp_skip = '0;
    for (int k = 0; k < N; k++) begin
      bit_c = grp_c;
      all_p = 1'b1;
      for (int j = 0; j < G; j++) begin
        sum[k*G+j] = prop[k*G+j] ^ bit_c;
        bit_c      = gen[k*G+j] | (prop[k*G+j] & bit_c);
        all_p      = all_p & prop[k*G+j];
      end
      grp_skip[k] = all_p;
      grp_c       = all_p ? grp_c : bit_c;
    end
    carry_out = grp_c;
  end
endmodule

// File: rtl/skip_adder_chk.sv
module skip_adder_chk #(
  parameter int W = 16,
  parameter int G = 4
) (
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic           carry_in,
  input logic [W-1:0]   sum,
  input logic           carry_out,
  input logic [W/G-1:0] grp_skip
);
  localparam int N = W / G;

  logic [W:0] full;
  logic [G:0] top;

  assign full = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};
  assign top  = {1'b0, op_a[W-1 -: G]} + {1'b0, op_b[W-1 -: G]};

  always_comb begin
    p_sum_r1: assert (sum == full[W-1:0])
      else $error("R1 sum mismatch");
    p_cout_r2: assert (carry_out == full[W])
      else $error("R2 carry_out mismatch");
    for (int k = 0; k < N; k++) begin
      p_skip_r3: assert (grp_skip[k] == (G'(op_a[k*G +: G] + op_b[k*G +: G]) == {G{1'b1}}))
        else $error("R3 skip select mismatch");
    end
    if (&grp_skip) begin
      p_all_skip_r4: assert (carry_out == carry_in && sum == {W{~carry_in}})
        else $error("R4 full bypass mismatch");
    end
    if (!grp_skip[N-1]) begin
      p_top_local_r5: assert (carry_out == top[G])
        else $error("R5 local carry mismatch");
    end
  end
endmodule

bind skip_adder skip_adder_chk #(.W(W), .G(G)) i_chk (
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
  .sum(sum), .carry_out(carry_out), .grp_skip(grp_skip)
);

// File: tb/test_skip_adder.sv
module test_skip_adder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum;
  logic        carry_out;
  logic [3:0]  grp_skip;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] lf = 32'h1234_5678;

  always #2 clk = ~clk;

  skip_adder i_skip_adder (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out), .grp_skip(grp_skip)
  );

  function automatic logic [31:0] step(logic [31:0] v);
    return (v << 1) ^ (v[31] ? 32'h04C1_1DB7 : 32'h0);
  endfunction

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [16:0] exp;
    logic [3:0]  exp_skip;
    logic [15:0] x;
    @(posedge clk);
    op_a = a; op_b = b; carry_in = c;
    @(negedge clk);
    exp = {1'b0, a} + {1'b0, b} + {16'b0, c};
    x = a ^ b;
    for (int k = 0; k < 4; k++) exp_skip[k] = (((x >> (4*k)) & 16'hF) == 16'hF);
    checks++;
    if (sum !== exp[15:0]) begin
      errors++;
      $display("FAIL R1 a=%h b=%h c=%b sum=%h expected %h", a, b, c, sum, exp[15:0]);
    end
    checks++;
    if (carry_out !== exp[16]) begin
      errors++;
      $display("FAIL R2 a=%h b=%h c=%b carry_out=%b expected %b", a, b, c, carry_out, exp[16]);
    end
    checks++;
    if (grp_skip !== exp_skip) begin
      errors++;
      $display("FAIL R3 a=%h b=%h grp_skip=%b expected %b", a, b, grp_skip, exp_skip);
    end
  endtask

  task automatic expect_val(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6: idle state with zero inputs
    expect_val("R6", {carry_out, sum}, 17'h0);
    expect_val("R6", {13'b0, grp_skip}, 17'h0);

    // R4: all groups propagate, carry passes the whole width
    apply(16'hFFFF, 16'h0000, 1'b1);
    expect_val("R4", {carry_out, sum}, 17'h1_0000);
    apply(16'h5A3C, 16'hA5C3, 1'b0);
    expect_val("R4", {carry_out, sum}, 17'h0_FFFF);
    apply(16'h5A3C, 16'hA5C3, 1'b1);
    expect_val("R4", {carry_out, sum}, 17'h1_0000);

    // R3 R4: every mix of skipping and non-skipping groups
    for (int m = 0; m < 16; m++) begin
      logic [15:0] a, b;
      for (int k = 0; k < 4; k++) begin
        a[4*k +: 4] = m[k] ? 4'h5 : 4'h3;
        b[4*k +: 4] = m[k] ? 4'hA : 4'h3;
      end
      for (int c = 0; c < 2; c++) begin
        apply(a, b, c[0]);
        expect_val("R3", {13'b0, grp_skip}, {13'b0, m[3:0]});
      end
    end

    // R5: top group generates or kills, carry_out ignores carry_in
    for (int c = 0; c < 2; c++) begin
      apply(16'h8FFF, 16'h8000, c[0]);
      expect_val("R5", {16'b0, carry_out}, 17'h1);
      apply(16'h0FFF, 16'h0000, c[0]);
      expect_val("R5", {16'b0, carry_out}, 17'h0);
      apply(16'h7FFF, 16'h7000, c[0]);
      expect_val("R5", {16'b0, carry_out}, 17'h0);
    end

    // R1 R2 R3: exhaustive nibble sweep of group 1 with carry-in, other bits pseudo-random
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          logic [15:0] ra, rb;
          lf = step(lf);
          ra = lf[15:0]; rb = lf[31:16];
          ra[7:4] = a[3:0]; rb[7:4] = b[3:0];
          apply(ra, rb, c[0]);
        end

    // R1 R2: pseudo-random vectors, half forced to heavy propagation
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ra, rb;
      lf = step(lf);
      ra = lf[15:0];
      rb = (i % 2 == 0) ? lf[31:16] : (~ra ^ (lf[31:16] & lf[15:0] & 16'h1111));
      apply(ra, rb, lf[7]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule